// File: doc/BRIEF.md
# Vertex and Texture Fetch Issue Queues

This block sits between a fetch dispatcher and two pools of fetch hardware, one for vertex fetches and one for texture fetches. Each cycle it can take up to two fetch requests. Each request carries a one-bit kind. The block holds them in order and issues each to a unit of its own kind as soon as that unit can take it. Each unit pool is modelled as one latency counter: an issue strobe starts the counter, and a completion strobe marks the end of the fixed latency.

A build-time switch picks one of two organisations. In the dedicated organisation, each kind has its own in-order queue and its own arbiter, so the two kinds never wait on each other. In the unified organisation, one in-order queue of twice the depth feeds both pools. There a blocked head entry stalls everything behind it. With the same request stream on both builds, the issue and completion strobes show the cost of head-of-line blocking cycle by cycle.

Top module: `fetch_dual_queue`

## Requirements
- R1: While reset is held, and in the first cycle after it, every queue is empty: `req_ready` is 2'b11 and no issue or completion strobe is high.
- R2: The kind bit is 0 for vertex and 1 for texture. In the dedicated build, each accepted request joins the queue of its own kind. `vtx_issue` fires only for vertex entries and `tex_issue` only for texture entries, at most once per kind per cycle.
- R3: In the dedicated build, slot 0 is ready when the queue of its kind holds fewer than QDEPTH entries. Slot 1 is ready when that occupancy, plus one if slot 0 is valid with the same kind, is below QDEPTH. Occupancy is taken at the start of the cycle, and an issue in the same cycle is not credited. Slot 0 is enqueued ahead of slot 1.
- R4: A request accepted at a clock edge issues no earlier than the following cycle. A queue issues its head in every cycle where it is non-empty and the unit of the head's kind is free. A unit is free when it is idle or in its completion cycle.
- R5: `vtx_done` pulses exactly VTX_LAT cycles after `vtx_issue`, where VTX_LAT is 1 or 2 and defaults to 2. `tex_done` pulses exactly TEX_LAT cycles after `tex_issue`, where TEX_LAT is 1. A unit accepts no new issue before its completion cycle.
- R6: In the unified build, slot 0 is ready when the total occupancy is below 2*QDEPTH. Slot 1 is ready when the occupancy plus one for a valid slot 0 is below 2*QDEPTH. Kind plays no part in either rule.
- R7: In the unified build, the head issues when its unit is free. The second entry issues in the same cycle only if the head issues, the second entry has the other kind, and its unit is free. No other entry issues.
- R8: In the dedicated build, a busy vertex unit never delays a texture issue, and a busy texture unit never delays a vertex issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 2 | Request valid per slot; slot 0 is older |
| req_kind | input | 2 | Request kind per slot, 0 vertex, 1 texture |
| req_ready | output | 2 | Slot can be accepted this cycle |
| vtx_issue | output | 1 | A vertex entry leaves for the vertex unit |
| tex_issue | output | 1 | A texture entry leaves for the texture unit |
| vtx_done | output | 1 | The vertex unit finishes a fetch |
| tex_done | output | 1 | The texture unit finishes a fetch |

## Verification
Suppose an occupancy count drifts by one. The ready pattern then goes wrong in the next cycle where the affected queue nears full. An issue also appears one cycle early when the queue drains, or never appears. A corrupted kind bit in the unified queue sends a strobe to the wrong pool in the cycle that entry reaches the head. A stuck latency counter shows as a missing or shifted completion strobe within VTX_LAT cycles of the issue.

// File: rtl/fetch_dq_pkg.sv
package fetch_dq_pkg;

  typedef enum logic {
    KIND_VTX = 1'b0,
    KIND_TEX = 1'b1
  } fetch_kind_e;

  // Room check for a slot: entries already held plus earlier slots this cycle
  function automatic logic has_room(input int occ, input int earlier, input int depth);
    return (occ + earlier) < depth;
  endfunction

  // Latency counter step: reload on start, else count down to zero
  function automatic int lat_next(input int cnt, input logic start, input int lat);
    if (start) return lat;
    if (cnt > 0) return cnt - 1;
    return 0;
  endfunction

endpackage

// File: rtl/fetch_lat_unit.sv
module fetch_lat_unit
  import fetch_dq_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic free,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= CW'(lat_next(int'(cnt), start, LAT));
  end

  assign done = (cnt == CW'(1));
  assign free = (cnt <= CW'(1));
endmodule

// File: rtl/fetch_kind_fifo.sv
module fetch_kind_fifo #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push,
  input  logic [1:0]    din,
  input  logic [1:0]    pop_n,
  output logic          head,
  output logic          second,
  output logic [CW-1:0] occ
);
  logic [DEPTH-1:0] mem, nmem;
  logic [CW-1:0]    nocc;

  always_comb begin
    int base;
    nmem = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) nmem[i] = mem[i + int'(pop_n)];
    end
    base = int'(occ) - int'(pop_n);
    if (push[0]) begin
      for (int i = 0; i < DEPTH; i++) if (i == base) nmem[i] = din[0];
      base = base + 1;
    end
    if (push[1]) begin
      for (int i = 0; i < DEPTH; i++) if (i == base) nmem[i] = din[1];
      base = base + 1;
    end
    nocc = CW'(base);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
      occ <= '0;
    end else begin
      mem <= nmem;
      occ <= nocc;
    end
  end

  assign head   = mem[0];
  assign second = mem[(DEPTH > 1) ? 1 : 0];
endmodule

// File: rtl/fetch_dual_queue.sv
module fetch_dual_queue
  import fetch_dq_pkg::*;
#(
  parameter int QDEPTH  = 2,
  parameter int VTX_LAT = 2,
  parameter int TEX_LAT = 1,
  parameter bit UNIFIED = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req_valid,
  input  logic [1:0] req_kind,
  output logic [1:0] req_ready,
  output logic       vtx_issue,
  output logic       tex_issue,
  output logic       vtx_done,
  output logic       tex_done
);
  localparam int UDEPTH = 2 * QDEPTH;
  localparam int CW_D   = $clog2(QDEPTH + 1);
  localparam int CW_U   = $clog2(UDEPTH + 1);

  // Named internal events, also observed by the bound checker
  logic            vtx_free, tex_free;
  logic [1:0]      acc;
  logic [CW_U-1:0] occ_a, occ_b;
  logic            head_a, head_b, second_a, second_b;

  assign acc = req_valid & req_ready;

  fetch_lat_unit #(.LAT(VTX_LAT)) u_vtx (
    .clk(clk), .rst(rst), .start(vtx_issue), .free(vtx_free), .done(vtx_done)
  );
  fetch_lat_unit #(.LAT(TEX_LAT)) u_tex (
    .clk(clk), .rst(rst), .start(tex_issue), .free(tex_free), .done(tex_done)
  );

  generate
    if (!UNIFIED) begin : g_ded
      logic [1:0]      push_v, push_t;
      logic [CW_D-1:0] occ_v, occ_t;
      logic            same_kind;

      assign push_v    = acc & ~req_kind;
      assign push_t    = acc & req_kind;
      assign same_kind = req_valid[0] && (req_kind[0] == req_kind[1]);

      fetch_kind_fifo #(.DEPTH(QDEPTH)) q_vtx (
        .clk(clk), .rst(rst), .push(push_v), .din(req_kind),
        .pop_n({1'b0, vtx_issue}), .head(head_a), .second(second_a), .occ(occ_v)
      );
      fetch_kind_fifo #(.DEPTH(QDEPTH)) q_tex (
        .clk(clk), .rst(rst), .push(push_t), .din(req_kind),
        .pop_n({1'b0, tex_issue}), .head(head_b), .second(second_b), .occ(occ_t)
      );

      assign req_ready[0] = has_room(int'(req_kind[0] ? occ_t : occ_v), 0, QDEPTH);
      assign req_ready[1] = has_room(int'(req_kind[1] ? occ_t : occ_v),
                                     int'(same_kind), QDEPTH);

      assign vtx_issue = (occ_v != '0) && vtx_free && (head_a == KIND_VTX);
      assign tex_issue = (occ_t != '0) && tex_free && (head_b == KIND_TEX);

      assign occ_a = CW_U'(occ_v);
      assign occ_b = CW_U'(occ_t);
    end else begin : g_uni
      logic [1:0] pop_u;
      logic       head_go, next_go;

      fetch_kind_fifo #(.DEPTH(UDEPTH)) q_uni (
        .clk(clk), .rst(rst), .push(acc), .din(req_kind),
        .pop_n(pop_u), .head(head_a), .second(second_a), .occ(occ_a)
      );

      assign req_ready[0] = has_room(int'(occ_a), 0, UDEPTH);
      assign req_ready[1] = has_room(int'(occ_a), int'(req_valid[0]), UDEPTH);

      // Head-of-line: only the head, or the head plus a partner of the other kind
      assign head_go = (occ_a != '0) && (head_a ? tex_free : vtx_free);
      assign next_go = head_go && (occ_a >= CW_U'(2)) && (second_a != head_a)
                       && (second_a ? tex_free : vtx_free);
      assign pop_u   = {1'b0, head_go} + {1'b0, next_go};

      assign vtx_issue = (head_go && !head_a) || (next_go && !second_a);
      assign tex_issue = (head_go && head_a)  || (next_go && second_a);

      assign occ_b    = '0;
      assign head_b   = 1'b0;
      assign second_b = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fetch_dual_queue_chk.sv
module fetch_dual_queue_chk #(
  parameter int QDEPTH  = 2,
  parameter int VTX_LAT = 2,
  parameter int TEX_LAT = 1,
  parameter bit UNIFIED = 1'b0
) (
  input logic                            clk,
  input logic                            rst,
  input logic [1:0]                      req_valid,
  input logic [1:0]                      req_kind,
  input logic [1:0]                      req_ready,
  input logic                            vtx_issue,
  input logic                            tex_issue,
  input logic                            vtx_done,
  input logic                            tex_done,
  input logic [$clog2(2*QDEPTH+1)-1:0]   occ_a,
  input logic [$clog2(2*QDEPTH+1)-1:0]   occ_b,
  input logic                            head_a,
  input logic                            head_b,
  input logic                            second_a,
  input logic                            second_b
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vtx_issue && !tex_issue && !vtx_done && !tex_done)); // R1

  AST_VTX_LAT: assert property (@(posedge clk) disable iff (rst)
    vtx_done == $past(vtx_issue, VTX_LAT)); // R5
  AST_TEX_LAT: assert property (@(posedge clk) disable iff (rst)
    tex_done == $past(tex_issue, TEX_LAT)); // R5

  generate
    if (VTX_LAT > 1) begin : g_vbusy
      AST_VTX_BUSY: assert property (@(posedge clk) disable iff (rst)
        vtx_issue |=> !vtx_issue); // R5
    end

    if (!UNIFIED) begin : g_ded
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(occ_a) <= QDEPTH) && (int'(occ_b) <= QDEPTH)); // R3
      AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (int'(occ_a) == QDEPTH) |-> !(req_ready[0] && !req_kind[0])); // R3
      AST_SLOT1_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((int'(occ_a) == QDEPTH - 1) && req_valid[0] && !req_kind[0] && !req_kind[1])
        |-> !req_ready[1]); // R3
      AST_VTX_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        vtx_issue |-> (occ_a != '0)); // R4
      AST_TEX_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        tex_issue |-> (occ_b != '0)); // R4
      AST_VQ_KIND: assert property (@(posedge clk) disable iff (rst)
        ((occ_a != '0) |-> !head_a) and ((int'(occ_a) >= 2) |-> !second_a)); // R2
      AST_TQ_KIND: assert property (@(posedge clk) disable iff (rst)
        ((occ_b != '0) |-> head_b) and ((int'(occ_b) >= 2) |-> second_b)); // R2
    end else begin : g_uni
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(occ_a) <= 2 * QDEPTH); // R6
      AST_SLOT1_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((int'(occ_a) == 2 * QDEPTH - 1) && req_valid[0]) |-> !req_ready[1]); // R6
      AST_ISSUE_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (vtx_issue || tex_issue) |-> (occ_a != '0)); // R4
      AST_HOL_VTX: assert property (@(posedge clk) disable iff (rst)
        ((occ_a != '0) && !head_a && !vtx_issue) |-> !tex_issue); // R7
      AST_HOL_TEX: assert property (@(posedge clk) disable iff (rst)
        ((occ_a != '0) && head_a && !tex_issue) |-> !vtx_issue); // R7
      AST_PAIR: assert property (@(posedge clk) disable iff (rst)
        (vtx_issue && tex_issue) |-> ((int'(occ_a) >= 2) && (second_a != head_a))); // R7
    end
  endgenerate
endmodule

bind fetch_dual_queue fetch_dual_queue_chk #(
  .QDEPTH(QDEPTH), .VTX_LAT(VTX_LAT), .TEX_LAT(TEX_LAT), .UNIFIED(UNIFIED)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_ready(req_ready), .vtx_issue(vtx_issue), .tex_issue(tex_issue),
  .vtx_done(vtx_done), .tex_done(tex_done), .occ_a(occ_a), .occ_b(occ_b),
  .head_a(head_a), .head_b(head_b), .second_a(second_a), .second_b(second_b)
);

// File: tb/fetch_dual_queue_tb_top.sv
module fetch_dual_queue_tb_top;
  localparam int QD = 2;
  localparam int NM = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rv = '0;
  logic [1:0] rk = '0;
  logic [1:0] rdy [NM];
  logic       vi [NM];
  logic       ti [NM];
  logic       vd [NM];
  logic       td [NM];

  always #10 clk = ~clk;

  // 0: dedicated, vertex latency 2; 1: unified, latency 2; 2: dedicated, latency 1
  fetch_dual_queue #(.QDEPTH(QD), .VTX_LAT(2), .TEX_LAT(1), .UNIFIED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(rv), .req_kind(rk), .req_ready(rdy[0]),
    .vtx_issue(vi[0]), .tex_issue(ti[0]), .vtx_done(vd[0]), .tex_done(td[0]));
  fetch_dual_queue #(.QDEPTH(QD), .VTX_LAT(2), .TEX_LAT(1), .UNIFIED(1'b1)) dut_u_i (
    .clk(clk), .rst(rst), .req_valid(rv), .req_kind(rk), .req_ready(rdy[1]),
    .vtx_issue(vi[1]), .tex_issue(ti[1]), .vtx_done(vd[1]), .tex_done(td[1]));
  fetch_dual_queue #(.QDEPTH(QD), .VTX_LAT(1), .TEX_LAT(1), .UNIFIED(1'b0)) dut_l1_i (
    .clk(clk), .rst(rst), .req_valid(rv), .req_kind(rk), .req_ready(rdy[2]),
    .vtx_issue(vi[2]), .tex_issue(ti[2]), .vtx_done(vd[2]), .tex_done(td[2]));

  int n_chk = 0;
  int n_fail = 0;

  // Bench-side expectation state
  int uni [NM] = '{0, 1, 0};
  int vlat [NM] = '{2, 2, 1};
  int vcnt [NM];
  int tcnt [NM];
  int qv [NM];
  int qt [NM];
  int un [NM];
  bit uq [NM][2*QD];

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit [1:0] v, input bit [1:0] k);
    rv = v;
    rk = k;
    #2;
    for (int m = 0; m < NM; m++) begin
      bit vf, tf, evi, eti, er0, er1, a0, a1, hok, sok;
      int p, n;
      bit tmp [2*QD];
      vf = vcnt[m] <= 1;
      tf = tcnt[m] <= 1;
      if (uni[m] == 0) begin
        evi = (qv[m] > 0) && vf;
        eti = (qt[m] > 0) && tf;
        er0 = ((k[0] ? qt[m] : qv[m])) < QD;
        er1 = ((k[1] ? qt[m] : qv[m]) + ((v[0] && k[0] == k[1]) ? 1 : 0)) < QD;
        check("R3", $sformatf("dedicated ready m%0d", m), int'(rdy[m]), {er1, er0});
        check("R2 R4 R8", $sformatf("vertex issue m%0d", m), int'(vi[m]), int'(evi));
        check("R2 R4 R8", $sformatf("texture issue m%0d", m), int'(ti[m]), int'(eti));
      end else begin
        er0 = un[m] < 2 * QD;
        er1 = (un[m] + int'(v[0])) < 2 * QD;
        hok = (un[m] > 0) && (uq[m][0] ? tf : vf);
        sok = hok && (un[m] > 1) && (uq[m][1] != uq[m][0]) && (uq[m][1] ? tf : vf);
        evi = (hok && !uq[m][0]) || (sok && !uq[m][1]);
        eti = (hok && uq[m][0]) || (sok && uq[m][1]);
        check("R6", $sformatf("unified ready m%0d", m), int'(rdy[m]), {er1, er0});
        check("R7 R4", $sformatf("vertex issue m%0d", m), int'(vi[m]), int'(evi));
        check("R7 R4", $sformatf("texture issue m%0d", m), int'(ti[m]), int'(eti));
      end
      check("R5", $sformatf("vertex done m%0d", m), int'(vd[m]), int'(vcnt[m] == 1));
      check("R5", $sformatf("texture done m%0d", m), int'(td[m]), int'(tcnt[m] == 1));
      // Advance expectation state across the coming edge
      a0 = v[0] && er0;
      a1 = v[1] && er1;
      vcnt[m] = evi ? vlat[m] : (vcnt[m] > 0 ? vcnt[m] - 1 : 0);
      tcnt[m] = eti ? 1 : (tcnt[m] > 0 ? tcnt[m] - 1 : 0);
      if (uni[m] == 0) begin
        qv[m] = qv[m] - int'(evi) + int'(a0 && !k[0]) + int'(a1 && !k[1]);
        qt[m] = qt[m] - int'(eti) + int'(a0 && k[0]) + int'(a1 && k[1]);
      end else begin
        p = int'(hok) + int'(sok);
        for (int i = 0; i < 2 * QD; i++) tmp[i] = (i + p < 2 * QD) ? uq[m][i + p] : 1'b0;
        n = un[m] - p;
        if (a0) begin tmp[n] = k[0]; n++; end
        if (a1) begin tmp[n] = k[1]; n++; end
        for (int i = 0; i < 2 * QD; i++) uq[m][i] = tmp[i];
        un[m] = n;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pat(input int p, output bit [1:0] v, output bit [1:0] k);
    int s0, s1;
    s0 = p % 3;
    s1 = p / 3;
    v = {s1 != 0, s0 != 0};
    k = {s1 == 2, s0 == 2};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 2'b00);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit [1:0] v, k;
    int unsigned seed;
    for (int m = 0; m < NM; m++) begin
      vcnt[m] = 0; tcnt[m] = 0; qv[m] = 0; qt[m] = 0; un[m] = 0;
      for (int i = 0; i < 2 * QD; i++) uq[m][i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      check("R1", "ready in reset", int'(rdy[m]), 3);
      check("R1", "issue in reset", int'(vi[m]) + int'(ti[m]), 0);
      check("R1", "done in reset", int'(vd[m]) + int'(td[m]), 0);
    end
    rst = 1'b0;
    idle(2);

    // Mixed kind streams: paired kinds, one kind only, interleaved, late other kind
    step(2'b11, 2'b00); step(2'b11, 2'b11); idle(8);
    step(2'b11, 2'b00); step(2'b11, 2'b00); idle(10);
    step(2'b11, 2'b10); step(2'b11, 2'b10); step(2'b11, 2'b10); idle(10);
    step(2'b11, 2'b11); step(2'b11, 2'b11); step(2'b01, 2'b00); idle(10);

    // Sweep every three-cycle sequence of slot patterns
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++)
        for (int c = 0; c < 9; c++) begin
          pat(a, v, k); step(v, k);
          pat(b, v, k); step(v, k);
          pat(c, v, k); step(v, k);
          idle(6);
        end

    // Dense pseudo-random traffic keeps queues near full
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step({seed[20] | seed[21], seed[22] | seed[23]}, {seed[25], seed[27]});
    end
    idle(10);
    finish_run();
  end
endmodule